// File: doc/BRIEF.md
# Cubic Interpolating Fractional Delay Line

The block is a per-sample audio delay line. Every accepted input sample is written once into a circular buffer. An output sample is produced for each input at a fixed pipeline distance. No block buffering is involved, so the only latency added beyond the requested delay is the short pipeline. The read point comes from an unsigned fixed-point delay word with an integer part and an 8-bit fraction. Changes to that word move the read point smoothly between stored samples.

The output is a four-tap FIR over the stored samples around the read point. Its weights are cubic polynomials in the fraction f and are recomputed from f in fixed point on every sample. The halving terms in those polynomials are one-bit arithmetic shifts, not multiplies. The coefficient fraction has 3*FRAC_W+1 bits, so every weight is exact.

The block is meant for short, modulated delays in comb filters, plucked-string loops and flanging, where the feedback path lies outside the block.

Top module: `frac_delay_cubic`

## Requirements
- R1: For every cycle in which in_valid_i is sampled high at a rising edge k, out_valid_o is high for exactly the cycle that follows edge k+3, and out_valid_o is never high otherwise.
- R2: The newest written sample is s[n], and I is the integer field delay_i[ADDR_W+FRAC_W-1:FRAC_W]. When the fraction field delay_i[FRAC_W-1:0] is zero, the output equals s[n-I] exactly.
- R3: For a fraction f = delay_i[FRAC_W-1:0]/2^FRAC_W, the output is w0*s[n-I-1] + w1*s[n-I] + w2*s[n-I+1] + w3*s[n-I+2]. The weights are w0 = -0.5f^3+f^2-0.5f, w1 = 1.5f^3-2.5f^2+1, w2 = -1.5f^3+2f^2+0.5f and w3 = 0.5f^3-0.5f^2.
- R4: The four weights sum to exactly one for every fraction, so a constant input passes through unchanged. At f = 0 the weights are exactly 0, 1, 0, 0.
- R5: The weighted sum is rounded to the nearest integer, and an exact half rounds toward plus infinity.
- R6: A result above 2^(DATA_W-1)-1 is output as 2^(DATA_W-1)-1, and a result below -2^(DATA_W-1) is output as -2^(DATA_W-1).
- R7: The integer field is clamped to the range 2 to 2^ADDR_W-2 before use, so all four taps fall on samples still held in the buffer. The fraction field is used unchanged.
- R8: The buffer holds 2^ADDR_W samples, and all addressing wraps modulo that depth. Delays stay correct after any number of writes.
- R9: After reset out_valid_o is 0 and out_sample_o is 0. Between valid pulses out_sample_o holds its last value, and changes on in_sample_i or delay_i while in_valid_i is low have no effect on the output.
- R10: Reset clears the buffer, so taps that reach before the first written sample read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input sample strobe |
| in_sample_i | input | DATA_W | Signed input sample |
| delay_i | input | ADDR_W+FRAC_W | Unsigned delay: integer part above FRAC_W fraction bits |
| out_valid_o | output | 1 | Output sample strobe |
| out_sample_o | output | DATA_W | Signed interpolated output sample |

## Verification
The bench builds the block with ADDR_W = 5, a 32-entry buffer, and keeps DATA_W = 16 and FRAC_W = 8. With the small depth, wraparound of the circular buffer and the upper clamp of the integer delay at 30 come within a few dozen samples, so both edges are exercised many times over. The 16-bit width lets full-scale samples drive the overshoot of the cubic weights into both saturation limits. The 8-bit fraction gives exact half-way results at f = 0.5, which test the rounding rule.

// File: rtl/fdl_pkg.sv
package fdl_pkg;
  localparam int unsigned FDL_NTAPS   = 4;
  // taps sit at base-1 .. base+2
  localparam int unsigned FDL_TAP_LAG = 1;
  localparam int unsigned FDL_MIN_INT = 2;
  // edges from input strobe to output register
  localparam int unsigned FDL_LATENCY = 4;
endpackage

// File: rtl/fdl_ring.sv
module fdl_ring import fdl_pkg::*; #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic signed [DATA_W-1:0] wr_data_i,
  input  logic        [ADDR_W-1:0] int_i,
  output logic signed [DATA_W-1:0] taps_o [FDL_NTAPS]
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic signed [DATA_W-1:0] mem_q [DEPTH];
  logic [ADDR_W-1:0] wr_ptr_q, head_q, int_q, base;
  logic [ADDR_W-1:0] rd_addr [FDL_NTAPS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      wr_ptr_q <= '0;
      head_q   <= '0;
      int_q    <= ADDR_W'(FDL_MIN_INT);
    end else if (wr_en_i) begin
      mem_q[wr_ptr_q] <= wr_data_i;
      head_q          <= wr_ptr_q;
      int_q           <= int_i;
      wr_ptr_q        <= wr_ptr_q + ADDR_W'(1);
    end
  end

  assign base = head_q - int_q;

  always_comb begin
    for (int k = 0; k < FDL_NTAPS; k++)
      rd_addr[k] = base + ADDR_W'(k) - ADDR_W'(FDL_TAP_LAG);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < FDL_NTAPS; k++) taps_o[k] <= '0;
    end else begin
      for (int k = 0; k < FDL_NTAPS; k++) taps_o[k] <= mem_q[rd_addr[k]];
    end
  end
endmodule

// File: rtl/fdl_coef.sv
module fdl_coef import fdl_pkg::*; #(
  parameter int unsigned FRAC_W = 8,
  parameter int unsigned CW     = 3*FRAC_W + 1,
  parameter int unsigned COEF_W = CW + 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic        [FRAC_W-1:0] frac_i,
  output logic signed [COEF_W-1:0] w_o [FDL_NTAPS]
);
  localparam logic signed [COEF_W-1:0] ONE = COEF_W'(1) << CW;

  logic [2*FRAC_W-1:0] f2;
  logic [3*FRAC_W-1:0] f3;
  logic signed [COEF_W-1:0] t1, t2, t3, h1, h2, h3;
  logic signed [COEF_W-1:0] w_d [FDL_NTAPS];

  assign f2 = (2*FRAC_W)'(frac_i) * (2*FRAC_W)'(frac_i);
  assign f3 = (3*FRAC_W)'(f2) * (3*FRAC_W)'(frac_i);

  // f, f^2, f^3 scaled to CW fraction bits
  assign t1 = COEF_W'(frac_i) << (2*FRAC_W + 1);
  assign t2 = COEF_W'(f2) << (FRAC_W + 1);
  assign t3 = COEF_W'(f3) << 1;

  // halving by shift; exact due to extra LSB
  assign h1 = t1 >>> 1;
  assign h2 = t2 >>> 1;
  assign h3 = t3 >>> 1;

  always_comb begin
    w_d[0] = t2 - h3 - h1;
    w_d[1] = ONE + t3 + h3 - (t2 <<< 1) - h2;
    w_d[2] = (t2 <<< 1) + h1 - t3 - h3;
    w_d[3] = h3 - h2;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_o[0] <= '0;
      w_o[1] <= ONE;
      w_o[2] <= '0;
      w_o[3] <= '0;
    end else begin
      for (int k = 0; k < FDL_NTAPS; k++) w_o[k] <= w_d[k];
    end
  end
endmodule

// File: rtl/fdl_mac.sv
module fdl_mac import fdl_pkg::*; #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CW     = 25,
  parameter int unsigned COEF_W = CW + 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     take_i,
  input  logic signed [DATA_W-1:0] taps_i [FDL_NTAPS],
  input  logic signed [COEF_W-1:0] w_i [FDL_NTAPS],
  output logic signed [DATA_W-1:0] sample_o
);
  localparam int unsigned ACC_W = DATA_W + COEF_W + 2;
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((64'sd1 <<< (DATA_W-1)) - 64'sd1);
  localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - ACC_W'(1);
  localparam logic signed [ACC_W-1:0] HALF   = ACC_W'(1) << (CW-1);

  logic signed [ACC_W-1:0] prod [FDL_NTAPS];
  logic signed [ACC_W-1:0] sum_d, acc_q, rnd, scaled;
  logic signed [DATA_W-1:0] sat_d;

  for (genvar k = 0; k < FDL_NTAPS; k++) begin : g_tap
    assign prod[k] = ACC_W'(taps_i[k]) * ACC_W'(w_i[k]);
  end

  always_comb begin
    sum_d = '0;
    for (int k = 0; k < FDL_NTAPS; k++) sum_d = sum_d + prod[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= sum_d;
  end

  assign rnd    = acc_q + HALF;
  assign scaled = rnd >>> CW;

  always_comb begin
    if (scaled > SAT_HI)      sat_d = SAT_HI[DATA_W-1:0];
    else if (scaled < SAT_LO) sat_d = SAT_LO[DATA_W-1:0];
    else                      sat_d = scaled[DATA_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sample_o <= '0;
    else if (take_i) sample_o <= sat_d;
  end
endmodule

// File: rtl/frac_delay_cubic.sv
module frac_delay_cubic import fdl_pkg::*; #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned FRAC_W = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       in_valid_i,
  input  logic signed [DATA_W-1:0]   in_sample_i,
  input  logic [ADDR_W+FRAC_W-1:0]   delay_i,
  output logic                       out_valid_o,
  output logic signed [DATA_W-1:0]   out_sample_o
);
  localparam int unsigned DEPTH   = 1 << ADDR_W;
  localparam int unsigned CW      = 3*FRAC_W + 1;
  localparam int unsigned COEF_W  = CW + 3;
  localparam int unsigned INT_MAX = DEPTH - 2;

  logic [ADDR_W-1:0] int_raw, int_sel;
  logic [FRAC_W-1:0] frac_q;
  logic [FDL_LATENCY-1:0] vld_q;
  logic signed [DATA_W-1:0] taps [FDL_NTAPS];
  logic signed [COEF_W-1:0] coef_w [FDL_NTAPS];

  assign int_raw = delay_i[ADDR_W+FRAC_W-1:FRAC_W];

  always_comb begin
    if (int_raw < ADDR_W'(FDL_MIN_INT))  int_sel = ADDR_W'(FDL_MIN_INT);
    else if (int_raw > ADDR_W'(INT_MAX)) int_sel = ADDR_W'(INT_MAX);
    else                                 int_sel = int_raw;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frac_q <= '0;
      vld_q  <= '0;
    end else begin
      if (in_valid_i) frac_q <= delay_i[FRAC_W-1:0];
      vld_q <= {vld_q[FDL_LATENCY-2:0], in_valid_i};
    end
  end

  fdl_ring #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ring (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (in_valid_i),
    .wr_data_i (in_sample_i),
    .int_i     (int_sel),
    .taps_o    (taps)
  );

  fdl_coef #(.FRAC_W(FRAC_W), .CW(CW), .COEF_W(COEF_W)) u_coef (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .frac_i (frac_q),
    .w_o    (coef_w)
  );

  fdl_mac #(.DATA_W(DATA_W), .CW(CW), .COEF_W(COEF_W)) u_mac (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .take_i   (vld_q[FDL_LATENCY-2]),
    .taps_i   (taps),
    .w_i      (coef_w),
    .sample_o (out_sample_o)
  );

  assign out_valid_o = vld_q[FDL_LATENCY-1];
endmodule

// File: rtl/fdl_checker.sv
module fdl_checker import fdl_pkg::*; #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned FRAC_W = 8,
  parameter int unsigned CW     = 3*FRAC_W + 1,
  parameter int unsigned COEF_W = CW + 3
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     in_valid_i,
  input logic                     out_valid_o,
  input logic signed [DATA_W-1:0] out_sample_o,
  input logic        [ADDR_W-1:0] int_sel,
  input logic        [FRAC_W-1:0] frac_q,
  input logic signed [COEF_W-1:0] coef_w [FDL_NTAPS]
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam logic signed [COEF_W+1:0] ONE_S = (COEF_W+2)'(1) << CW;
  localparam logic signed [COEF_W-1:0] ONE_W = COEF_W'(1) << CW;

  logic [2:0] cnt_q;
  logic signed [COEF_W+1:0] wsum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q != 3'd7) cnt_q <= cnt_q + 3'd1;
  end

  always_comb begin
    wsum = '0;
    for (int k = 0; k < FDL_NTAPS; k++) wsum = wsum + (COEF_W+2)'(coef_w[k]);
  end

  AST_OUT_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q >= 3'd4) |-> (out_valid_o == $past(in_valid_i, 4))); // R1

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != 3'd0 && !out_valid_o) |-> $stable(out_sample_o)); // R9

  AST_WEIGHT_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != 3'd0) |-> (wsum == ONE_S)); // R4

  AST_ZERO_FRAC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != 3'd0 && $past(frac_q) == '0) |->
      (coef_w[0] == '0 && coef_w[1] == ONE_W && coef_w[2] == '0 && coef_w[3] == '0)); // R4

  AST_INT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> (int_sel >= ADDR_W'(FDL_MIN_INT) && int_sel <= ADDR_W'(DEPTH-2))); // R7
endmodule

bind frac_delay_cubic fdl_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FRAC_W(FRAC_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_valid_i   (in_valid_i),
  .out_valid_o  (out_valid_o),
  .out_sample_o (out_sample_o),
  .int_sel      (int_sel),
  .frac_q       (frac_q),
  .coef_w       (coef_w)
);

// File: tb/frac_delay_cubic_bench.sv
`timescale 1ns/1ps
module frac_delay_cubic_bench;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 5;
  localparam int FRAC_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [DATA_W-1:0] in_sample = '0;
  logic [ADDR_W+FRAC_W-1:0] delay = '0;
  logic out_valid;
  logic signed [DATA_W-1:0] out_sample;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int n_wr = 0;
  logic signed [DATA_W-1:0] hist [0:1023];
  int    exp_val_q [$];
  int    exp_cyc_q [$];
  string exp_tag_q [$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  frac_delay_cubic #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .FRAC_W(FRAC_W)) u_frac_delay_cubic (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_sample_i(in_sample),
    .delay_i(delay), .out_valid_o(out_valid), .out_sample_o(out_sample)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // reference from the stated weights, scaled by 2^25
  function automatic int model(input int ri, input int fi);
    int ii;
    longint f, acc, r, idx;
    longint w [4];
    ii = (ri < 2) ? 2 : ((ri > DEPTH-2) ? DEPTH-2 : ri);
    f = fi;
    w[0] = -f*f*f + 512*f*f - 65536*f;
    w[1] = 3*f*f*f - 1280*f*f + (64'sd1 <<< 25);
    w[2] = -3*f*f*f + 1024*f*f + 65536*f;
    w[3] = f*f*f - 256*f*f;
    acc = 0;
    for (int k = 0; k < 4; k++) begin
      idx = longint'(n_wr) - 2 - ii + k;
      if (idx >= 0) acc += longint'(hist[idx]) * w[k];
    end
    r = (acc + (64'sd1 <<< 24)) >>> 25;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic push(input int s, input int ri, input int fi, input string tag);
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = DATA_W'(s);
    delay     = {ADDR_W'(ri), FRAC_W'(fi)};
    hist[n_wr] = DATA_W'(s);
    n_wr++;
    exp_val_q.push_back(model(ri, fi));
    exp_cyc_q.push_back(cyc + 4);
    exp_tag_q.push_back(tag);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_val_q.size() == 0) begin
        chk(1'b0, "R1 spurious valid", 1, 0);
      end else begin
        int ev, ec;
        string tg;
        ev = exp_val_q.pop_front();
        ec = exp_cyc_q.pop_front();
        tg = exp_tag_q.pop_front();
        chk(cyc == ec, "R1 latency", cyc, ec);
        chk(int'(out_sample) == ev, tg, int'(out_sample), ev);
      end
    end
  end

  task automatic t_reset();
    chk(out_valid == 1'b0, "R9 reset valid", int'(out_valid), 0);
    chk(out_sample == '0, "R9 reset sample", int'(out_sample), 0);
  endtask

  task automatic t_cleared();
    push(5000, 2, 128, "R10 cleared taps");
    push(-7000, 30, 64, "R10 cleared taps far");
    idle(6);
    chk(exp_val_q.size() == 0, "R1 outputs drained", exp_val_q.size(), 0);
  endtask

  task automatic t_integer();
    for (int i = 0; i < 36; i++) push(i*731 - 9000, 2 + (i % 20), 0, "R2 integer delay");
    idle(6);
  endtask

  task automatic t_frac();
    int fr [6] = '{1, 64, 128, 200, 255, 37};
    for (int i = 0; i < 6; i++) push((i*4099) % 20000 - 10000, 3 + i, fr[i], "R3 fractional");
    idle(6);
  endtask

  task automatic t_dc();
    for (int i = 0; i < 40; i++) push(1234, 2 + (i % 28), (i*53) % 256, "R4 dc passthrough");
    idle(6);
  endtask

  task automatic t_round();
    push(-8, 2, 0, "R5 setup");
    push(0, 2, 0, "R5 setup");
    push(0, 2, 0, "R5 setup");
    push(0, 2, 128, "R5 half up positive");
    push(8, 2, 0, "R5 setup");
    push(0, 2, 0, "R5 setup");
    push(0, 2, 0, "R5 setup");
    push(0, 2, 128, "R5 half up negative");
    idle(6);
  endtask

  task automatic t_sat();
    push(-32768, 2, 0, "R6 setup");
    push(32767, 2, 0, "R6 setup");
    push(32767, 2, 0, "R6 setup");
    push(-32768, 2, 128, "R6 saturate high");
    push(32767, 2, 0, "R6 setup");
    push(-32768, 2, 0, "R6 setup");
    push(-32768, 2, 0, "R6 setup");
    push(32767, 2, 128, "R6 saturate low");
    idle(6);
  endtask

  task automatic t_clamp();
    for (int i = 0; i < 34; i++) push(i*977 - 15000, 5, 0, "R7 fill");
    push(111, 0, 90, "R7 clamp int 0");
    push(222, 1, 0, "R7 clamp int 1");
    push(333, 31, 170, "R7 clamp int 31");
    push(444, 31, 0, "R7 clamp int 31 exact");
    idle(6);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 80; i++)
      push((i*2711) % 30000 - 15000, 2 + (i*7) % 29, (i*97) % 256, "R8 wraparound");
    idle(6);
  endtask

  task automatic t_hold();
    logic signed [DATA_W-1:0] held;
    push(3210, 4, 77, "R9 hold setup");
    idle(6);
    held = out_sample;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      in_sample = DATA_W'(i*1000 - 2000);
      delay     = {ADDR_W'(i + 3), FRAC_W'(i*40)};
      chk(out_valid == 1'b0, "R9 no valid while idle", int'(out_valid), 0);
      chk(out_sample == held, "R9 output held", int'(out_sample), int'(held));
    end
  endtask

  task automatic t_burst();
    for (int i = 0; i < 12; i++) push(i*2500 - 14000, 2 + i, i*21, "R1 back to back");
    idle(6);
    chk(exp_val_q.size() == 0, "R1 burst drained", exp_val_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_cleared();
    t_integer();
    t_frac();
    t_dc();
    t_round();
    t_sat();
    t_clamp();
    t_wrap();
    t_hold();
    t_burst();
    idle(4);
    chk(exp_val_q.size() == 0, "R1 final drain", exp_val_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(64'd200000 * 20);
    chk(1'b0, "R1 watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule